// File: doc/BRIEF.md
# Boolean Condition Evaluator and Qualified Trigger Delay

This block turns a set of asynchronous handshake lines into clean, clock-aligned condition signals for a pattern timing engine. Ten qualifier lines and the trigger line each pass through a two-flop synchronizer. Two ready lines are first combined by an AND gate and then pass through the same kind of synchronizer. The synchronized qualifier word addresses a writable 1024 x 4 truth-table memory. Each bit of a word is one user-defined Boolean function of the ten lines. The three lower bits go out registered as handshake conditions. The top bit is used only to decide whether a trigger edge counts.

A trigger edge of the selected polarity is accepted only if the qualifying bit of the truth table is true in the same cycle that the edge is detected. An accepted trigger starts a 16-bit countdown and leaves the block as a single-cycle pulse once the programmed number of clock periods has elapsed. Edges that arrive while a countdown runs are dropped. Software fills the truth table through a simple address/data write port while the block is idle.

Top module: `cq_cond_trigger`

## Requirements
- R1: `ready_out` equals `rdy_a AND rdy_b` as sampled two rising clock edges earlier.
- R2: `cond_out[2:0]` equals bits 2:0 of the truth-table word addressed by `qual_in`, with a latency of three rising edges after `qual_in` changes. Bit k of a word is condition k.
- R3: A write with `tt_we` high stores `tt_wdata` at `tt_addr`. Later reads of that address return the new word.
- R4: With `trig_fall_sel` = 0, rising edges of `trig_in` are the trigger events and falling edges are ignored.
- R5: With `trig_fall_sel` = 1, falling edges of `trig_in` are the trigger events and rising edges are ignored.
- R6: An edge is accepted only if bit 3 of the truth-table word addressed by the synchronized `qual_in` is 1 in the edge cycle. Otherwise no pulse appears on `trig_out`.
- R7: An accepted edge with delay value D produces `trig_out` high after rising edge 3+D, counted from the change on `trig_in`. D = 0 gives 3.
- R8: Trigger edges detected while a countdown is in progress are ignored and produce no extra pulse.
- R9: While `rst` is high, `ready_out`, `cond_out` and `trig_out` are all 0 after the next clock edge.
- R10: Each `trig_out` pulse lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| qual_in | input | 10 | Asynchronous qualifier lines |
| rdy_a | input | 1 | First asynchronous ready line |
| rdy_b | input | 1 | Second asynchronous ready line |
| trig_in | input | 1 | Asynchronous trigger line |
| trig_fall_sel | input | 1 | Trigger slope: 0 rising, 1 falling |
| trig_delay | input | 16 | Trigger release delay in clock periods |
| tt_we | input | 1 | Truth-table write enable |
| tt_addr | input | 10 | Truth-table write address |
| tt_wdata | input | 4 | Truth-table write word |
| ready_out | output | 1 | Synchronized AND of the ready lines |
| cond_out | output | 3 | Registered handshake conditions |
| trig_out | output | 1 | Delayed qualified trigger pulse |

## Verification
The bench uses the default parameters: ten qualifier lines, four table bits, a 16-bit delay and two synchronizer stages. With these values every one of the 1024 table addresses is written from a reference function and can be read back. Qualifier patterns include all-zero, all-one and alternating-bit words. Delays of 0, 2, 5 and 20 place the release pulse at exact cycle counts. The 20-cycle countdown leaves room to insert a second edge that must be dropped.

// File: rtl/cq_pkg.sv
package cq_pkg;

    localparam int CQ_QUAL_W     = 10;
    localparam int CQ_COND_W     = 4;
    localparam int CQ_DLY_W      = 16;
    localparam int CQ_SYNC_DEPTH = 2;

    typedef enum logic {
        SLOPE_RISE = 1'b0,
        SLOPE_FALL = 1'b1
    } slope_e;

    // True when the synchronized line moved in the selected direction.
    function automatic logic slope_hit(slope_e sel, logic now_v, logic prev_v);
        return (sel == SLOPE_FALL) ? (prev_v & ~now_v) : (now_v & ~prev_v);
    endfunction

endpackage

// File: rtl/cq_sync.sv
module cq_sync #(
    parameter int W     = 1,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [DEPTH];

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[DEPTH-1];
endmodule

// File: rtl/cq_truth_table.sv
module cq_truth_table #(
    parameter int AW = 10,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cq_trig_delay.sv
module cq_trig_delay #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic [DW-1:0] delay,
    output logic          pulse,
    output logic          busy
);
    typedef struct packed {
        logic          run;
        logic [DW-1:0] left;
    } cnt_state_t;

    cnt_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (st.run) begin
                if (st.left == DW'(1)) begin
                    pulse  <= 1'b1;
                    st.run <= 1'b0;
                end else begin
                    st.left <= st.left - DW'(1);
                end
            end else if (fire) begin
                if (delay == '0) begin
                    pulse <= 1'b1;
                end else begin
                    st.run  <= 1'b1;
                    st.left <= delay;
                end
            end
        end
    end

    assign busy = st.run;
endmodule

// File: rtl/cq_cond_trigger.sv
module cq_cond_trigger
    import cq_pkg::*;
#(
    parameter int QUAL_W     = CQ_QUAL_W,
    parameter int COND_W     = CQ_COND_W,
    parameter int DLY_W      = CQ_DLY_W,
    parameter int SYNC_DEPTH = CQ_SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [QUAL_W-1:0] qual_in,
    input  logic              rdy_a,
    input  logic              rdy_b,
    input  logic              trig_in,
    input  logic              trig_fall_sel,
    input  logic [DLY_W-1:0]  trig_delay,
    input  logic              tt_we,
    input  logic [QUAL_W-1:0] tt_addr,
    input  logic [COND_W-1:0] tt_wdata,
    output logic              ready_out,
    output logic [COND_W-2:0] cond_out,
    output logic              trig_out
);
    localparam int HS_W  = COND_W - 1;
    localparam int IN_W  = QUAL_W + 2;
    localparam int RDY_B = QUAL_W;
    localparam int TRG_B = QUAL_W + 1;

    logic [IN_W-1:0]   raw_bus;
    logic [IN_W-1:0]   sync_bus;
    logic [QUAL_W-1:0] qual_s;
    logic              trig_s;
    logic              trig_prev;
    logic [COND_W-1:0] tt_rd;
    logic [HS_W-1:0]   cond_r;
    logic              edge_hit;
    logic              fire;
    logic              busy;

    assign raw_bus = {trig_in, rdy_a & rdy_b, qual_in};

    cq_sync #(.W(IN_W), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_bus),
        .q   (sync_bus)
    );

    assign qual_s    = sync_bus[QUAL_W-1:0];
    assign trig_s    = sync_bus[TRG_B];
    assign ready_out = sync_bus[RDY_B];

    cq_truth_table #(.AW(QUAL_W), .DW(COND_W)) u_tt (
        .clk   (clk),
        .we    (tt_we),
        .waddr (tt_addr),
        .wdata (tt_wdata),
        .raddr (qual_s),
        .rdata (tt_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_r    <= '0;
            trig_prev <= 1'b0;
        end else begin
            cond_r    <= tt_rd[HS_W-1:0];
            trig_prev <= trig_s;
        end
    end

    assign cond_out = cond_r;
    assign edge_hit = slope_hit(slope_e'(trig_fall_sel), trig_s, trig_prev);
    assign fire     = edge_hit & tt_rd[COND_W-1];

    cq_trig_delay #(.DW(DLY_W)) u_dly (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .delay (trig_delay),
        .pulse (trig_out),
        .busy  (busy)
    );
endmodule

// File: rtl/cq_cond_trigger_chk.sv
module cq_cond_trigger_chk #(
    parameter int COND_W = 4,
    parameter int DLY_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              rdy_a,
    input logic              rdy_b,
    input logic              ready_out,
    input logic [COND_W-2:0] cond_out,
    input logic              trig_out,
    input logic [COND_W-1:0] tt_rd,
    input logic              edge_hit,
    input logic              fire,
    input logic              busy,
    input logic [DLY_W-1:0]  trig_delay
);
    logic [1:0] warm;

    always_ff @(posedge clk) begin
        if (rst)              warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    AST_READY_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2) |-> (ready_out == $past(rdy_a && rdy_b, 2))); // R1

    AST_COND_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd1) |-> (cond_out == $past(tt_rd[COND_W-2:0]))); // R2

    AST_UNQUALIFIED_DROP: assert property (@(posedge clk) disable iff (rst)
        (edge_hit && !tt_rd[COND_W-1] && !busy) |=> (!trig_out && !busy)); // R6

    AST_ZERO_DELAY: assert property (@(posedge clk) disable iff (rst)
        (fire && !busy && trig_delay == '0) |=> trig_out); // R7

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        trig_out |=> !trig_out); // R10

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!trig_out && !ready_out && cond_out == '0)); // R9
endmodule

bind cq_cond_trigger cq_cond_trigger_chk #(.COND_W(COND_W), .DLY_W(DLY_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rdy_a      (rdy_a),
    .rdy_b      (rdy_b),
    .ready_out  (ready_out),
    .cond_out   (cond_out),
    .trig_out   (trig_out),
    .tt_rd      (tt_rd),
    .edge_hit   (edge_hit),
    .fire       (fire),
    .busy       (busy),
    .trig_delay (trig_delay)
);

// File: tb/tb_cq_cond_trigger.sv
module tb_cq_cond_trigger;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  qual_in = '0;
    logic        rdy_a = 1'b0;
    logic        rdy_b = 1'b0;
    logic        trig_in = 1'b0;
    logic        trig_fall_sel = 1'b0;
    logic [15:0] trig_delay = '0;
    logic        tt_we = 1'b0;
    logic [9:0]  tt_addr = '0;
    logic [3:0]  tt_wdata = '0;
    logic        ready_out;
    logic [2:0]  cond_out;
    logic        trig_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cq_cond_trigger dut (
        .clk(clk), .rst(rst), .qual_in(qual_in), .rdy_a(rdy_a), .rdy_b(rdy_b),
        .trig_in(trig_in), .trig_fall_sel(trig_fall_sel), .trig_delay(trig_delay),
        .tt_we(tt_we), .tt_addr(tt_addr), .tt_wdata(tt_wdata),
        .ready_out(ready_out), .cond_out(cond_out), .trig_out(trig_out)
    );

    typedef struct packed {
        logic [9:0] q;
        logic       a;
        logic       b;
        logic [2:0] cnd;
        logic       rdy;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{10'h000, 1'b1, 1'b1, 3'b000, 1'b1},
        '{10'h003, 1'b1, 1'b0, 3'b001, 1'b0},
        '{10'h155, 1'b0, 1'b1, 3'b110, 1'b0},
        '{10'h3FF, 1'b1, 1'b1, 3'b001, 1'b1},
        '{10'h201, 1'b0, 1'b0, 3'b000, 1'b0},
        '{10'h007, 1'b1, 1'b1, 3'b011, 1'b1}
    };

    // bit0 = q0&q1, bit1 = parity, bit2 = (q==0x155), bit3 (trigger qualifier) = q9
    function automatic logic [3:0] ref_word(logic [9:0] a);
        return {a[9], a == 10'h155, ^a, a[0] & a[1]};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called just after a negedge; drives trig_in and watches span cycles.
    task automatic run_trig(input logic val, input int span, output int first, output int hits);
        first = -1;
        hits  = 0;
        trig_in = val;
        for (int i = 1; i <= span; i++) begin
            @(negedge clk);
            if (trig_out) begin
                hits++;
                if (first < 0) first = i;
            end
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int first;
        int hits;
        repeat (3) @(negedge clk);
        check("R9 reset ready", int'(ready_out), 0);
        check("R9 reset cond", int'(cond_out), 0);
        check("R9 reset trig", int'(trig_out), 0);
        rst = 1'b0;

        // R3: fill the truth table from the reference function
        for (int a = 0; a < 1024; a++) begin
            tt_we    = 1'b1;
            tt_addr  = 10'(a);
            tt_wdata = ref_word(10'(a));
            @(negedge clk);
        end
        tt_we = 1'b0;

        // R1 / R2 vector walk
        foreach (VECS[k]) begin
            qual_in = VECS[k].q;
            rdy_a   = VECS[k].a;
            rdy_b   = VECS[k].b;
            repeat (3) @(negedge clk);
            check("R2 cond vector", int'(cond_out), int'(VECS[k].cnd));
            check("R1 ready vector", int'(ready_out), int'(VECS[k].rdy));
        end

        // R1 exact latency: ready rises after two edges, not one
        rdy_a = 1'b0; rdy_b = 1'b1;
        repeat (3) @(negedge clk);
        rdy_a = 1'b1;
        @(negedge clk);
        check("R1 ready after one edge", int'(ready_out), 0);
        @(negedge clk);
        check("R1 ready after two edges", int'(ready_out), 1);

        // R7 / R4 / R10: qualifier true, rising slope, zero delay
        qual_in = 10'h200; trig_fall_sel = 1'b0; trig_delay = 16'd0;
        repeat (4) @(negedge clk);
        run_trig(1'b1, 12, first, hits);
        check("R7 zero delay latency", first, 3);
        check("R10 single pulse", hits, 1);
        run_trig(1'b0, 12, first, hits);
        check("R4 falling ignored", hits, 0);

        // R7: delay 5
        trig_delay = 16'd5;
        run_trig(1'b1, 20, first, hits);
        check("R7 delay five latency", first, 8);
        check("R10 delay five width", hits, 1);
        run_trig(1'b0, 8, first, hits);

        // R5: falling slope, delay 2
        trig_fall_sel = 1'b1; trig_delay = 16'd2;
        run_trig(1'b1, 12, first, hits);
        check("R5 rising ignored", hits, 0);
        run_trig(1'b0, 12, first, hits);
        check("R5 falling latency", first, 5);

        // R6: qualifier false
        trig_fall_sel = 1'b0; trig_delay = 16'd0;
        qual_in = 10'h000;
        repeat (4) @(negedge clk);
        run_trig(1'b1, 12, first, hits);
        check("R6 unqualified dropped", hits, 0);
        run_trig(1'b0, 4, first, hits);

        // R8: second edge during a running count
        qual_in = 10'h200; trig_delay = 16'd20;
        repeat (4) @(negedge clk);
        first = -1; hits = 0;
        trig_in = 1'b1;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            if (trig_out) begin
                hits++;
                if (first < 0) first = i;
            end
            if (i == 4) trig_in = 1'b0;
            if (i == 7) trig_in = 1'b1;
        end
        check("R8 busy edge ignored count", hits, 1);
        check("R8 first pulse timing", first, 23);
        trig_in = 1'b0;
        repeat (4) @(negedge clk);

        // R3: rewrite one entry and read it through cond_out
        tt_we = 1'b1; tt_addr = 10'h0AA; tt_wdata = 4'b0101;
        @(negedge clk);
        tt_we = 1'b0;
        qual_in = 10'h0AA;
        repeat (3) @(negedge clk);
        check("R3 rewritten entry", int'(cond_out), 5);

        // R9: reset in mid-operation
        rst = 1'b1;
        @(negedge clk);
        check("R9 reset mid cond", int'(cond_out), 0);
        check("R9 reset mid ready", int'(ready_out), 0);
        rst = 1'b0;

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule